// File: doc/BRIEF.md
# Exclusive Region Lock Tracker

This block follows an exclusive resource lock on a shared parallel bus. It watches the lock line, the start and end strobes of each transaction, the transaction address, the ID of the master that started it, and a direction flag. When a master takes the lock, the block records that master as the owner. It also records the 16-byte region, aligned on a 16-byte boundary, that the owner's first transaction addressed. Other masters keep using the bus. Only their downstream accesses that fall inside the locked region are refused, by a one-cycle retry pulse.

Holding the bus and holding the lock are separate. A fixed-priority arbiter grants the bus on request. In the normal mode it grants any requester, whether or not a lock is held. In complete-lock mode, while a lock is held, only the owner can be granted. The one exception is a request marked as a cache writeback. Write posting is switched off for as long as the lock is held.

Top module: `bus_lock_tracker`

## Requirements
- R1: The locked region is the transaction address with its low 4 bits dropped (`lock_region` = `txn_addr[31:4]`). An access by another master to any byte of that 16-byte block is refused, and an access to a neighbouring block is not.
- R2: A lock is taken in two steps while no lock is held. First, a downstream `txn_start` arrives with `lock_sig` low, which captures the master and the region. Then, at the matching `txn_done`, `lock_sig` must be high: `lock_held` rises on the next cycle. If `lock_sig` is low at `txn_done`, no lock is taken and the capture is dropped.
- R3: While the lock is held, a downstream access by another master outside the region is not refused, and an access by the owner to any address is not refused.
- R4: `post_en` is 0 in every cycle in which `lock_held` is 1, and 1 in every other cycle.
- R5: A held lock is released, and owner and region are cleared to 0, on the cycle after one in which `lock_sig` is low and `bus_idle` is high. Low `lock_sig` alone does not release it.
- R6: `retry` is high for exactly the cycle after a refused `txn_start`. A refused access leaves `lock_held`, `lock_owner` and `lock_region` unchanged.
- R7: Upstream transactions (`txn_down` = 0) never start a lock and are never refused.
- R8: `bus_grant` is one-hot or zero. Bit i is set only if `bus_req[i]` is set, and the lowest-indexed eligible requester wins. In normal mode (`full_lock_mode` = 0) every requester is eligible, even while a lock is held.
- R9: In complete-lock mode with a lock held, a requester is eligible only if it is the owner or has its `wb_req` bit set.
- R10: In complete-lock mode with a lock held, a requester flagged in `wb_req` is granted even though it is not the owner.
- R11: After reset, `lock_held`, `retry`, `lock_owner` and `lock_region` are 0 and `post_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Address phase of a transaction |
| txn_done | input | 1 | Last cycle of the current transaction |
| txn_addr | input | 32 | Transaction byte address |
| txn_master | input | 2 | ID of the initiating master |
| txn_down | input | 1 | 1 = downstream (away from the processor) |
| lock_sig | input | 1 | Bus lock line, active high |
| bus_idle | input | 1 | No transaction in progress on the bus |
| full_lock_mode | input | 1 | 1 = complete-bus-lock arbitration |
| bus_req | input | 4 | Bus request per master |
| wb_req | input | 4 | Request is a snoop-caused cache writeback |
| bus_grant | output | 4 | One-hot bus grant |
| retry | output | 1 | Access refused, one-cycle pulse |
| post_en | output | 1 | Write posting allowed |
| lock_held | output | 1 | A lock is active |
| lock_owner | output | 2 | Master ID of the lock owner |
| lock_region | output | 28 | Address bits above the 16-byte offset |

## Verification
The assertions assume that `txn_master` always names one of the configured masters and that `txn_done` only matters while a transaction is being tracked. Any other combination of strobes must leave the block in a legal state. The random stimulus keeps addresses in a few adjacent 16-byte blocks so that region hits are frequent. It also drives `lock_sig`, `bus_idle`, the strobes and the mode freely, so releases, refused accesses and failed lock attempts all occur.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int BL_ADDR_W    = 32;
    localparam int BL_GRAN_LOG2 = 4;
    localparam int BL_MASTERS   = 4;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_PEND = 2'd1,
        LK_HELD = 2'd2
    } lk_state_e;

    function automatic logic [BL_MASTERS-1:0] id_to_onehot(input int unsigned id);
        logic [BL_MASTERS-1:0] v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bl_region_match.sv
module bl_region_match #(
    parameter int REG_W = 28
) (
    input  logic [REG_W-1:0] probe,
    input  logic [REG_W-1:0] locked,
    output logic             hit
);
    always_comb hit = (probe == locked);
endmodule

// File: rtl/bl_lock_fsm.sv
module bl_lock_fsm
    import bl_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int REG_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_start,
    input  logic             txn_done,
    input  logic             txn_down,
    input  logic             lock_sig,
    input  logic             bus_idle,
    input  logic [ID_W-1:0]  txn_id,
    input  logic [REG_W-1:0] txn_region,
    input  logic             region_hit,
    output logic             held,
    output logic [ID_W-1:0]  owner,
    output logic [REG_W-1:0] region,
    output logic             retry,
    output logic             post_en
);
    typedef struct packed {
        lk_state_e        st;
        logic [ID_W-1:0]  own;
        logic [REG_W-1:0] reg_q;
        logic             rty;
    } lk_ctx_t;

    lk_ctx_t cur, nxt;

    always_comb begin
        nxt     = cur;
        nxt.rty = 1'b0;
        unique case (cur.st)
            LK_IDLE: begin
                if (txn_start && txn_down && !lock_sig) begin
                    nxt.st    = LK_PEND;
                    nxt.own   = txn_id;
                    nxt.reg_q = txn_region;
                end
            end
            LK_PEND: begin
                if (txn_done) begin
                    if (lock_sig) begin
                        nxt.st = LK_HELD;
                    end else begin
                        nxt.st    = LK_IDLE;
                        nxt.own   = '0;
                        nxt.reg_q = '0;
                    end
                end
            end
            LK_HELD: begin
                nxt.rty = txn_start && txn_down && (txn_id != cur.own) && region_hit;
                if (!lock_sig && bus_idle) begin
                    nxt.st    = LK_IDLE;
                    nxt.own   = '0;
                    nxt.reg_q = '0;
                end
            end
            default: begin
                nxt.st    = LK_IDLE;
                nxt.own   = '0;
                nxt.reg_q = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st    <= LK_IDLE;
            cur.own   <= '0;
            cur.reg_q <= '0;
            cur.rty   <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        held    = (cur.st == LK_HELD);
        owner   = (cur.st == LK_HELD) ? cur.own : '0;
        region  = (cur.st == LK_HELD) ? cur.reg_q : '0;
        retry   = cur.rty;
        post_en = (cur.st != LK_HELD);
    end

    assert_take_needs_lock_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> $past(lock_sig && txn_done));

    assert_release_needs_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(held) |-> $past(!lock_sig && bus_idle));

    assert_retry_from_lock_R6: assert property (@(posedge clk) disable iff (rst)
        retry |-> $past(held && txn_start && txn_down));

    assert_retry_keeps_owner_R6: assert property (@(posedge clk) disable iff (rst)
        (retry && held) |-> ($stable(owner) && $stable(region)));

    assert_upstream_no_retry_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!txn_down) |-> !retry);

    assert_reset_state_R11: assert property (@(posedge clk)
        $past(rst) |-> (!held && !retry && post_en));
endmodule

// File: rtl/bl_arbiter.sv
module bl_arbiter #(
    parameter int N_MASTERS = 4,
    parameter int ID_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] wb_req,
    input  logic                 full_mode,
    input  logic                 lock_held,
    input  logic [ID_W-1:0]      owner,
    output logic [N_MASTERS-1:0] grant
);
    logic [N_MASTERS-1:0] owner_oh;
    logic [N_MASTERS-1:0] eligible;
    logic [N_MASTERS:0]   taken;

    always_comb begin
        owner_oh = '0;
        owner_oh[owner] = 1'b1;
    end

    always_comb begin
        if (full_mode && lock_held)
            eligible = req & (owner_oh | wb_req);
        else
            eligible = req;
    end

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < N_MASTERS; i++) begin : g_prio
        assign grant[i]   = eligible[i] && !taken[i];
        assign taken[i+1] = taken[i] || eligible[i];
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    assert_full_lock_owner_R9: assert property (@(posedge clk) disable iff (rst)
        (full_mode && lock_held) |-> ((grant & ~(owner_oh | wb_req)) == '0));

    assert_writeback_served_R10: assert property (@(posedge clk) disable iff (rst)
        (full_mode && lock_held && (req & wb_req) != '0) |-> (grant != '0));
endmodule

// File: rtl/bus_lock_tracker.sv
module bus_lock_tracker
    import bl_pkg::*;
#(
    parameter int ADDR_W    = BL_ADDR_W,
    parameter int GRAN_LOG2 = BL_GRAN_LOG2,
    parameter int N_MASTERS = BL_MASTERS,
    localparam int ID_W     = $clog2(N_MASTERS),
    localparam int REG_W    = ADDR_W - GRAN_LOG2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 txn_start,
    input  logic                 txn_done,
    input  logic [ADDR_W-1:0]    txn_addr,
    input  logic [ID_W-1:0]      txn_master,
    input  logic                 txn_down,
    input  logic                 lock_sig,
    input  logic                 bus_idle,
    input  logic                 full_lock_mode,
    input  logic [N_MASTERS-1:0] bus_req,
    input  logic [N_MASTERS-1:0] wb_req,
    output logic [N_MASTERS-1:0] bus_grant,
    output logic                 retry,
    output logic                 post_en,
    output logic                 lock_held,
    output logic [ID_W-1:0]      lock_owner,
    output logic [REG_W-1:0]     lock_region
);
    logic [REG_W-1:0] txn_region;
    logic             region_hit;

    assign txn_region = txn_addr[ADDR_W-1:GRAN_LOG2];

    bl_region_match #(.REG_W(REG_W)) i_match (
        .probe  (txn_region),
        .locked (lock_region),
        .hit    (region_hit)
    );

    bl_lock_fsm #(.ID_W(ID_W), .REG_W(REG_W)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .txn_start  (txn_start),
        .txn_done   (txn_done),
        .txn_down   (txn_down),
        .lock_sig   (lock_sig),
        .bus_idle   (bus_idle),
        .txn_id     (txn_master),
        .txn_region (txn_region),
        .region_hit (region_hit),
        .held       (lock_held),
        .owner      (lock_owner),
        .region     (lock_region),
        .retry      (retry),
        .post_en    (post_en)
    );

    bl_arbiter #(.N_MASTERS(N_MASTERS), .ID_W(ID_W)) i_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (bus_req),
        .wb_req    (wb_req),
        .full_mode (full_lock_mode),
        .lock_held (lock_held),
        .owner     (lock_owner),
        .grant     (bus_grant)
    );

    assert_post_off_when_held_R4: assert property (@(posedge clk) disable iff (rst)
        lock_held |-> !post_en);

    assert_retry_not_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (retry && lock_held) |-> ($past(txn_master) != lock_owner));
endmodule

// File: tb/test_bus_lock_tracker.sv
`timescale 1ns/1ps
module test_bus_lock_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        txn_start, txn_done, txn_down, lock_sig, bus_idle, full_lock_mode;
    logic [31:0] txn_addr;
    logic [1:0]  txn_master;
    logic [3:0]  bus_req, wb_req, bus_grant;
    logic        retry, post_en, lock_held;
    logic [1:0]  lock_owner;
    logic [27:0] lock_region;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bus_lock_tracker i_bus_lock_tracker (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_done(txn_done),
        .txn_addr(txn_addr), .txn_master(txn_master), .txn_down(txn_down),
        .lock_sig(lock_sig), .bus_idle(bus_idle), .full_lock_mode(full_lock_mode),
        .bus_req(bus_req), .wb_req(wb_req), .bus_grant(bus_grant),
        .retry(retry), .post_en(post_en), .lock_held(lock_held),
        .lock_owner(lock_owner), .lock_region(lock_region)
    );

    // reference state
    int          m_st;     // 0 idle, 1 pending, 2 held
    logic [1:0]  m_own;
    logic [27:0] m_reg;
    logic        m_rty;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_grant(input logic [3:0] rq, input logic [3:0] wb,
                                             input logic fm, input logic held, input logic [1:0] own);
        logic [3:0] el;
        el = (fm && held) ? (rq & ((4'b1 << own) | wb)) : rq;
        for (int i = 0; i < 4; i++)
            if (el[i]) return 4'b1 << i;
        return 4'b0;
    endfunction

    task automatic model_step();
        logic nr;
        nr = 1'b0;
        case (m_st)
            0: if (txn_start && txn_down && !lock_sig) begin
                   m_st = 1; m_own = txn_master; m_reg = txn_addr[31:4];
               end
            1: if (txn_done) begin
                   if (lock_sig) m_st = 2;
                   else begin m_st = 0; m_own = 0; m_reg = 0; end
               end
            default: begin
                nr = txn_start && txn_down && (txn_master != m_own) && (txn_addr[31:4] == m_reg);
                if (!lock_sig && bus_idle) begin m_st = 0; m_own = 0; m_reg = 0; end
            end
        endcase
        m_rty = nr;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        txn_start = 0; txn_done = 0; txn_down = 1; lock_sig = 0; bus_idle = 0;
        full_lock_mode = 0; txn_addr = 0; txn_master = 0; bus_req = 0; wb_req = 0;
    endtask

    task automatic start_txn(input logic [1:0] id, input logic [31:0] a, input logic dn);
        txn_start = 1; txn_master = id; txn_addr = a; txn_down = dn;
        tick();
        txn_start = 0; txn_down = 1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        rst = 1;
        m_st = 0; m_own = 0; m_reg = 0; m_rty = 0;
        @(negedge clk); @(posedge clk); @(negedge clk);
        rst = 0;
        // R11 reset state
        check("R11 held", lock_held, 0);
        check("R11 post_en", post_en, 1);
        check("R11 owner/region", {lock_owner, lock_region}, 0);
        check("R11 retry", retry, 0);

        // R2 failed attempt: lock low at done
        start_txn(2'd3, 32'h0000_2000, 1);
        txn_done = 1; tick(); txn_done = 0;
        check("R2 no lock without lock_sig", lock_held, 0);

        // R7 upstream does not start a lock
        start_txn(2'd1, 32'h0000_1234, 0);
        lock_sig = 1; txn_done = 1; tick(); txn_done = 0;
        check("R7 upstream no lock", lock_held, 0);
        lock_sig = 0; tick();

        // R2 lock taken by master 1 at 0x1234
        start_txn(2'd1, 32'h0000_1234, 1);
        check("R2 not yet held", lock_held, 0);
        lock_sig = 1; tick();
        txn_done = 1; tick(); txn_done = 0;
        check("R2 held", lock_held, 1);
        check("R2 owner", lock_owner, 1);
        check("R1 region", lock_region, 28'h123);
        check("R4 posting off", post_en, 0);

        // R1/R6 other master into region
        start_txn(2'd2, 32'h0000_123C, 1);
        check("R6 retry pulse", retry, 1);
        check("R6 state kept", {lock_held, lock_owner, lock_region}, {1'b1, 2'd1, 28'h123});
        tick();
        check("R6 retry one cycle", retry, 0);
        start_txn(2'd0, 32'h0000_1230, 1);
        check("R1 low byte of region refused", retry, 1);
        start_txn(2'd2, 32'h0000_1240, 1);
        check("R1 neighbour block not refused", retry, 0);
        start_txn(2'd2, 32'h0000_5000, 1);
        check("R3 outside region", retry, 0);
        start_txn(2'd1, 32'h0000_1238, 1);
        check("R3 owner not refused", retry, 0);
        start_txn(2'd2, 32'h0000_1230, 0);
        check("R7 upstream not refused", retry, 0);

        // arbitration while held
        bus_req = 4'b1111; wb_req = 4'b0000; full_lock_mode = 0;
        #1 check("R8 normal mode lowest index", bus_grant, 4'b0001);
        full_lock_mode = 1;
        #1 check("R9 full lock owner only", bus_grant, 4'b0010);
        bus_req = 4'b1101;
        #1 check("R9 owner absent grants none", bus_grant, 4'b0000);
        wb_req = 4'b1000;
        #1 check("R10 writeback granted", bus_grant, 4'b1000);
        bus_req = 0; wb_req = 0; full_lock_mode = 0;

        // R5 release
        lock_sig = 0; bus_idle = 0; tick();
        check("R5 not released while busy", lock_held, 1);
        bus_idle = 1; tick();
        check("R5 released", lock_held, 0);
        check("R5 cleared", {lock_owner, lock_region}, 0);
        check("R4 posting back on", post_en, 1);
        bus_idle = 0;

        // random phase
        for (int c = 0; c < 4000; c++) begin
            txn_start  = ($urandom % 10) < 4;
            txn_done   = ($urandom % 10) < 3;
            txn_down   = ($urandom % 10) < 9;
            lock_sig   = ($urandom % 2);
            bus_idle   = ($urandom % 4) == 0;
            txn_master = 2'($urandom);
            txn_addr   = 32'h0000_0100 + ($urandom % 64);
            full_lock_mode = (c / 500) % 2;
            bus_req    = 4'($urandom);
            wb_req     = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
            #1;
            check((full_lock_mode ? (wb_req != 0 ? "R10 grant" : "R9 grant") : "R8 grant"),
                  bus_grant, exp_grant(bus_req, wb_req, full_lock_mode, m_st == 2, m_own));
            tick();
            check("R2 R5 held", lock_held, m_st == 2);
            check("R4 post_en", post_en, m_st != 2);
            check("R6 retry", retry, m_rty);
            check("R1 owner/region", {lock_owner, lock_region},
                  (m_st == 2) ? {m_own, m_reg} : 30'd0);
        end

        report();
    end
endmodule